// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Controller

This block decides, every cycle, where the two ALU operands of a five-stage in-order integer pipeline come from, and whether the front of the pipeline must wait. It compares the source register numbers of the instruction now in execute against the destinations carried in the two later pipeline buffers, the execute/memory buffer and the memory/writeback buffer. From that it produces a select code for each operand multiplexer. It also compares the sources of the instruction in decode against the destination of a load now in execute. If a load feeds the very next instruction, it holds the program counter and the fetch/decode buffer for one cycle and turns the decode/execute buffer into an empty slot whose write-enable is clear.

The register file is assumed to write in the first half of a cycle and read in the second half. A result in writeback is therefore already visible to decode, and no path from writeback into decode exists. Only read-after-write dependences are handled. Sources are always read in stage two and results are always written in stage five, so the other two dependence orders cannot occur.

A build-time parameter removes the bypass network. The selects then stay on the register file, and the interlock widens to cover producers in execute and in memory. A consumer placed right behind its producer then waits two cycles. All pins are plain combinational control: there is no data stream and no handshake.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select uses code 2'b00 for the register file value, 2'b01 for the execute/memory buffer result and 2'b10 for the memory/writeback buffer result; `fwd_a` serves `ex_rs1` and `fwd_b` serves `ex_rs2`, and both are 2'b00 when nothing matches.
- R2: When both later buffers hold the same destination that an execute source names, the select is 2'b01, the younger result.
- R3: A destination of register 0 never drives a select away from 2'b00 and never causes a stall.
- R4: A buffer entry whose write-enable is clear is never a bypass source and never causes a stall.
- R5: With the bypass enabled, a load in execute whose destination is a used source of the decode instruction raises `stall` and `bubble` for exactly one cycle; the consumer then reaches execute with select 2'b10. `bubble` equals `stall` at all times.
- R6: A decode source whose used flag is low never causes a stall.
- R7: With the bypass enabled, a non-load producer causes no stall, and a load with one instruction between it and its consumer causes no stall.
- R8: With the bypass disabled, both selects stay at 2'b00; a consumer directly behind its producer stalls two cycles, and one with a single instruction between stalls one cycle.
- R9: A producer that has reached writeback never causes a stall, in either configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | REG_W | First source register of the execute instruction |
| ex_rs2 | input | REG_W | Second source register of the execute instruction |
| ex_rd | input | REG_W | Destination held in the decode/execute buffer |
| ex_wen | input | 1 | Write-enable held in the decode/execute buffer |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination held in the execute/memory buffer |
| mem_wen | input | 1 | Write-enable held in the execute/memory buffer |
| wb_rd | input | REG_W | Destination held in the memory/writeback buffer |
| wb_wen | input | 1 | Write-enable held in the memory/writeback buffer |
| fwd_a | output | 2 | Select code for operand A |
| fwd_b | output | 2 | Select code for operand B |
| stall | output | 1 | Hold program counter and fetch/decode buffer |
| bubble | output | 1 | Load an empty slot into the decode/execute buffer |

## Verification
The bench runs short instruction sequences through a behavioural pipeline model and compares selects and stalls every cycle. It also totals the stall cycles of each sequence against the counts the requirements fix. It targets the case where two producers write the same register, where a design with reversed priority would hand the consumer a stale value. It also targets register 0 and cleared write-enables, where a careless match would stall or bypass for nothing. Load spacing of zero, one and two instructions is covered in both configurations, so an off-by-one interlock window shows up as a wrong stall total. A wrongly included writeback check would add stalls the split-cycle register file does not need.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_EXMEM = 2'b01,
    SRC_MEMWB = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hz_dest_match.sv
module hz_dest_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_wen,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  // register 0 is hardwired, so it is never a producer
  assign hit = dst_wen && (dst != ZERO_REG) && (dst == src);
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]  src,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic              mem_wen,
  input  logic [REG_W-1:0]  wb_rd,
  input  logic              wb_wen,
  output hz_pkg::opnd_src_e sel
);
  logic near_hit, far_hit;

  hz_dest_match #(.REG_W(REG_W)) u_near (
    .src(src), .dst(mem_rd), .dst_wen(mem_wen), .hit(near_hit)
  );
  hz_dest_match #(.REG_W(REG_W)) u_far (
    .src(src), .dst(wb_rd), .dst_wen(wb_wen), .hit(far_hit)
  );

  // younger producer wins
  always_comb begin
    if (near_hit)     sel = hz_pkg::SRC_EXMEM;
    else if (far_hit) sel = hz_pkg::SRC_MEMWB;
    else              sel = hz_pkg::SRC_RF;
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int REG_W = 5,
  parameter int NWIN  = 1
) (
  input  logic [1:0][REG_W-1:0]    src,
  input  logic [1:0]               src_used,
  input  logic [NWIN-1:0][REG_W-1:0] win_rd,
  input  logic [NWIN-1:0]          win_wen,
  output logic                     stall
);
  localparam int NSRC = 2;
  localparam int NCMP = NSRC * NWIN;

  logic [NCMP-1:0] cmp_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic raw_hit;
      hz_dest_match #(.REG_W(REG_W)) u_cmp (
        .src(src[s]), .dst(win_rd[w]), .dst_wen(win_wen[w]), .hit(raw_hit)
      );
      assign cmp_hit[w*NSRC+s] = raw_hit && src_used[s];
    end
  end

  assign stall = |cmp_hit;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_W  = 5,
  parameter int FWD_EN = 1
) (
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_rs1_used,
  input  logic             id_rs2_used,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble
);
  logic [1:0][REG_W-1:0] id_src;
  logic [1:0]            id_used;
  logic                  hold;

  assign id_src  = {id_rs2, id_rs1};
  assign id_used = {id_rs2_used, id_rs1_used};

  if (FWD_EN != 0) begin : g_fwd
    logic [1:0][REG_W-1:0] ex_src;
    hz_pkg::opnd_src_e     sel [2];
    logic [0:0][REG_W-1:0] win_rd;
    logic [0:0]            win_wen;

    assign ex_src = {ex_rs2, ex_rs1};

    for (genvar k = 0; k < 2; k++) begin : g_opnd
      hz_operand_sel #(.REG_W(REG_W)) u_sel (
        .src(ex_src[k]), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .sel(sel[k])
      );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    // only a load in execute is too late to bypass
    assign win_rd[0]  = ex_rd;
    assign win_wen[0] = ex_wen && ex_load;

    hz_interlock #(.REG_W(REG_W), .NWIN(1)) u_lock (
      .src(id_src), .src_used(id_used),
      .win_rd(win_rd), .win_wen(win_wen), .stall(hold)
    );
  end else begin : g_nofwd
    logic [1:0][REG_W-1:0] win_rd;
    logic [1:0]            win_wen;

    assign fwd_a = hz_pkg::SRC_RF;
    assign fwd_b = hz_pkg::SRC_RF;

    // wait until the producer reaches writeback
    assign win_rd  = {mem_rd, ex_rd};
    assign win_wen = {mem_wen, ex_wen};

    hz_interlock #(.REG_W(REG_W), .NWIN(2)) u_lock (
      .src(id_src), .src_used(id_used),
      .win_rd(win_rd), .win_wen(win_wen), .stall(hold)
    );
  end

  assign stall  = hold;
  assign bubble = hold;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_W  = 5,
  parameter int FWD_EN = 1
) (
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic             id_rs1_used,
  input logic             id_rs2_used,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_wen,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             stall,
  input logic             bubble
);
  localparam logic [REG_W-1:0] R0 = '0;

  always_comb begin
    a_r1_code_legal: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
      else $error("R1 illegal select code");
    a_r2_younger_first: assert (!(FWD_EN != 0 && mem_wen && mem_rd != R0 &&
                                  mem_rd == ex_rs1) || fwd_a == 2'b01)
      else $error("R2 execute/memory result not preferred");
    a_r3_zero_reg: assert (ex_rs1 != R0 || fwd_a == 2'b00)
      else $error("R3 register 0 bypassed");
    a_r4_far_needs_wen: assert (fwd_b != 2'b10 || (wb_wen && wb_rd == ex_rs2))
      else $error("R4 writeback select without a writing entry");
    a_r5_bubble_tracks_stall: assert (stall == bubble)
      else $error("R5 bubble differs from stall");
    a_r6_unused_src: assert ((id_rs1_used || id_rs2_used) || !stall)
      else $error("R6 stall with no used source");
    a_r8_no_bypass: assert (FWD_EN != 0 || (fwd_a == 2'b00 && fwd_b == 2'b00))
      else $error("R8 select moved with bypass disabled");
    a_r9_stall_source: assert (!stall || (ex_wen && ex_rd != R0) ||
                               (FWD_EN == 0 && mem_wen && mem_rd != R0))
      else $error("R9 stall without a producer in execute or memory");
    a_r7_load_only: assert (!(FWD_EN != 0 && stall) || ex_load)
      else $error("R7 stall behind a non-load");
  end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W), .FWD_EN(FWD_EN)) u_chk (.*);

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSCN = 8;

  typedef struct packed {
    logic       v;
    logic [4:0] rd, rs1, rs2;
    logic       u1, u2, we, ld;
  } ins_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic [4:0] mem_rd = '0, wb_rd = '0;
  logic id_rs1_used = 1'b0, id_rs2_used = 1'b0, ex_wen = 1'b0, ex_load = 1'b0;
  logic mem_wen = 1'b0, wb_wen = 1'b0;
  logic [1:0] fa_f, fb_f, fa_n, fb_n;
  logic st_f, bu_f, st_n, bu_n;

  int errors = 0;
  int checks = 0;
  ins_t prog[$];

  pipe_hazard_ctrl #(.REG_W(5), .FWD_EN(1)) dut (
    .id_rs1, .id_rs2, .id_rs1_used, .id_rs2_used, .ex_rs1, .ex_rs2, .ex_rd,
    .ex_wen, .ex_load, .mem_rd, .mem_wen, .wb_rd, .wb_wen,
    .fwd_a(fa_f), .fwd_b(fb_f), .stall(st_f), .bubble(bu_f));

  pipe_hazard_ctrl #(.REG_W(5), .FWD_EN(0)) dut_nf (
    .id_rs1, .id_rs2, .id_rs1_used, .id_rs2_used, .ex_rs1, .ex_rs2, .ex_rd,
    .ex_wen, .ex_load, .mem_rd, .mem_wen, .wb_rd, .wb_wen,
    .fwd_a(fa_n), .fwd_b(fb_n), .stall(st_n), .bubble(bu_n));

  function automatic ins_t mk(int rd, int rs1, int rs2, bit u1, bit u2, bit we, bit ld);
    ins_t t;
    t.v = 1'b1; t.rd = 5'(rd); t.rs1 = 5'(rs1); t.rs2 = 5'(rs2);
    t.u1 = u1; t.u2 = u2; t.we = we; t.ld = ld;
    return t;
  endfunction

  // does instruction p hand a new value of register r to a later reader
  function automatic bit writes(ins_t p, logic [4:0] r);
    return p.v && p.we && p.rd != 5'd0 && p.rd == r;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic load_scn(int s);
    prog.delete();
    case (s)
      0: begin prog.push_back(mk(1,2,0,1,0,1,1)); prog.push_back(mk(3,1,5,1,1,1,0)); end
      1: begin prog.push_back(mk(1,2,3,1,1,1,0)); prog.push_back(mk(4,10,1,1,1,1,0));
               prog.push_back(mk(6,1,11,1,1,1,0)); end
      2: begin prog.push_back(mk(2,10,11,1,1,1,0)); prog.push_back(mk(2,12,13,1,1,1,0));
               prog.push_back(mk(4,2,14,1,1,1,0)); end
      3: begin prog.push_back(mk(0,2,0,1,0,1,1)); prog.push_back(mk(3,0,0,1,1,1,0)); end
      4: begin prog.push_back(mk(5,6,7,1,1,0,0)); prog.push_back(mk(8,5,5,1,1,1,0)); end
      5: begin prog.push_back(mk(7,2,0,1,0,1,1)); prog.push_back(mk(3,8,7,1,0,1,0)); end
      6: begin prog.push_back(mk(4,2,0,1,0,1,1)); prog.push_back(mk(12,10,11,1,1,1,0));
               prog.push_back(mk(13,4,14,1,1,1,0)); end
      default: begin prog.push_back(mk(4,2,0,1,0,1,1)); prog.push_back(mk(12,10,11,1,1,1,0));
               prog.push_back(mk(13,10,11,1,1,1,0)); prog.push_back(mk(14,15,4,1,1,1,0)); end
    endcase
  endtask

  task automatic run_scn(int s, bit fwd, int exp_total, string tag);
    ins_t id, ex, mem, wb, nop;
    int total = 0;
    nop = '0;
    load_scn(s);
    id = prog.pop_front(); ex = nop; mem = nop; wb = nop;
    for (int cyc = 0; cyc < 40; cyc++) begin
      logic [1:0] ea, eb, ga, gb;
      bit es, gs, gbub, dep_ex, dep_mem;
      @(posedge clk);
      id_rs1 = id.rs1; id_rs2 = id.rs2; id_rs1_used = id.v && id.u1; id_rs2_used = id.v && id.u2;
      ex_rs1 = ex.rs1; ex_rs2 = ex.rs2; ex_rd = ex.rd; ex_wen = ex.v && ex.we; ex_load = ex.ld;
      mem_rd = mem.rd; mem_wen = mem.v && mem.we; wb_rd = wb.rd; wb_wen = wb.v && wb.we;
      @(negedge clk);
      // expected operand sources: youngest earlier writer in memory, then writeback
      ea = 2'b00; eb = 2'b00;
      if (fwd) begin
        if (writes(mem, ex.rs1)) ea = 2'b01; else if (writes(wb, ex.rs1)) ea = 2'b10;
        if (writes(mem, ex.rs2)) eb = 2'b01; else if (writes(wb, ex.rs2)) eb = 2'b10;
      end
      dep_ex  = id.v && ((id.u1 && writes(ex, id.rs1)) || (id.u2 && writes(ex, id.rs2)));
      dep_mem = id.v && ((id.u1 && writes(mem, id.rs1)) || (id.u2 && writes(mem, id.rs2)));
      es = fwd ? (dep_ex && ex.ld) : (dep_ex || dep_mem);
      ga = fwd ? fa_f : fa_n; gb = fwd ? fb_f : fb_n;
      gs = fwd ? st_f : st_n; gbub = fwd ? bu_f : bu_n;
      check(ga == ea, "R1", $sformatf("scn%0d fwd=%0d cyc%0d fwd_a", s, fwd, cyc), ga, ea);
      check(gb == eb, "R1", $sformatf("scn%0d fwd=%0d cyc%0d fwd_b", s, fwd, cyc), gb, eb);
      check(gs == es, "R5", $sformatf("scn%0d fwd=%0d cyc%0d stall", s, fwd, cyc), gs, es);
      check(gbub == es, "R5", $sformatf("scn%0d fwd=%0d cyc%0d bubble", s, fwd, cyc), gbub, es);
      if (gs) total++;
      wb = mem; mem = ex;
      if (es) ex = nop;
      else begin
        ex = id;
        id = (prog.size() > 0) ? prog.pop_front() : nop;
      end
      if (!id.v && !ex.v && !mem.v && !wb.v) break;
    end
    check(total == exp_total, tag, $sformatf("scn%0d fwd=%0d stall cycles", s, fwd),
          total, exp_total);
  endtask

  initial begin
    #(CLK_PERIOD * 4000);
    errors++; checks++;
    $display("FAIL R5 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp_f [NSCN] = '{1, 0, 0, 0, 0, 0, 0, 0};
    int exp_n [NSCN] = '{2, 2, 2, 0, 0, 0, 1, 0};
    string tag_f [NSCN] = '{"R5", "R7", "R2", "R3", "R4", "R6", "R7", "R9"};
    string tag_n [NSCN] = '{"R8", "R8", "R8", "R3", "R4", "R6", "R8", "R9"};
    @(negedge clk);
    // idle inputs: all selects on the register file, no stall (R1)
    check(fa_f == 2'b00 && fb_f == 2'b00, "R1", "idle selects", {fa_f, fb_f}, 0);
    check(!st_f && !bu_f && !st_n && !bu_n, "R5", "idle stall", st_f | st_n, 0);
    for (int s = 0; s < NSCN; s++) run_scn(s, 1'b1, exp_f[s], tag_f[s]);
    for (int s = 0; s < NSCN; s++) run_scn(s, 1'b0, exp_n[s], tag_n[s]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule